// File: doc/BRIEF.md
# Filtered Edge Input Capture Unit

This block watches an asynchronous capture pin and, when an edge of the selected polarity is accepted, copies the value of a free-running counter into a capture register. At the same time it raises a capture event flag for one clock cycle. The counter is an input from elsewhere; this block only samples it. Three control inputs shape the behaviour: a polarity select that picks rising or falling edges, an arm input that allows or blocks captures, and a filter enable.

The pin first passes through a two-flop synchroniser. With the filter off, the first synchronised sample at a new level is accepted. With the filter on, the new level has to be seen on four back-to-back samples, taken at the full clock rate, before it is accepted. Pulses shorter than that are treated as noise. The accepted pin level is tracked at all times, whatever the polarity and arm settings, so neither enabling the unit nor flipping the polarity makes a capture out of a level the pin already holds.

Top module: `edge_capture_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, cap_val_o reads 0 and cap_evt_o reads 0.
- R2: With filt_en_i = 0, a pin level that is first sampled at rising clock edge k and differs from the accepted level is accepted at edge k+2. If it is the selected edge, cap_evt_o is 1 after edge k+2 and cap_val_o holds the cnt_i value that was present at edge k+2.
- R3: With filt_en_i = 1, a new pin level that is sampled at edges k, k+1, k+2 and k+3 is accepted at edge k+5, and the capture then happens as in R2. A pulse that is held for three samples or fewer causes no capture.
- R4: rise_sel_i = 1 selects rising edges (pin 0 to 1) and rise_sel_i = 0 selects falling edges (pin 1 to 0). An edge of the other polarity is tracked but causes no capture.
- R5: cap_evt_o is never high for two cycles in a row. One accepted edge causes exactly one capture, even when the pin level stays stable afterwards.
- R6: cap_val_o changes only at the edge where cap_evt_o is set, and it holds its value between captures.
- R7: While en_i = 0, no capture takes place and cap_val_o does not change. Edges that happen while the unit is disarmed are still tracked, so setting en_i back to 1 does not capture them later.
- R8: At an edge where rise_sel_i differs from its value at the previous edge, nothing is accepted and no capture takes place. The filter history is refilled with the accepted level, so an edge that was pending must qualify again. Toggling rise_sel_i while the pin is steady never causes a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; filter sampling also runs at this rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous capture pin |
| cnt_i | input | CNT_W (16) | Free-running counter value to be captured |
| en_i | input | 1 | Arm input: 1 allows captures |
| rise_sel_i | input | 1 | Edge select: 1 = rising, 0 = falling |
| filt_en_i | input | 1 | 1 = four-sample agreement filter on |
| cap_val_o | output | CNT_W (16) | Capture register |
| cap_evt_o | output | 1 | One-cycle pulse, high in the cycle after a capture |

## Verification
The bench measures the exact capture latency in both filter modes by changing the counter every cycle. A design that is off by one register, or that samples the counter on the wrong edge, therefore stores a neighbouring count. It sends pulses of three samples to the filter, which a filter with too short a window would turn into a capture. It also sends the opposite edge, which a design that ignores polarity would capture. It arms the unit after the pin has moved and flips the polarity while an edge is still in the synchroniser. A design that does not track the level while disarmed, or does not refill its history on a polarity change, would then capture a stale edge or capture at the wrong time. A long random phase with arbitrary control changes is compared cycle by cycle against a run-length model of the rules.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  localparam int unsigned CNT_W_DEF    = 16;
  localparam int unsigned FILT_LEN_DEF = 4;
  localparam int unsigned SYNC_DEF     = 2;

  localparam logic SEL_RISE = 1'b1;
  localparam logic SEL_FALL = 1'b0;

  // a newly accepted level is a selected edge when it equals the level the
  // chosen edge leads to (rising ends high, falling ends low)
  function automatic logic edge_selected(input logic new_lvl, input logic rise_sel);
    return (rise_sel == SEL_RISE) ? new_lvl : ~new_lvl;
  endfunction

endpackage

// File: rtl/ecap_sync.sv
module ecap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ecap_qual.sv
module ecap_qual
  import ecap_pkg::*;
#(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  input  logic rise_sel_i,
  input  logic filt_en_i,
  input  logic en_i,
  output logic agree_o,
  output logic pol_chg_o,
  output logic accept_o,
  output logic hit_o
);
  localparam int unsigned HIST_W = FILT_LEN - 1;
  localparam int unsigned WIN_W  = FILT_LEN;

  logic [HIST_W-1:0] hist_q, hist_d;
  logic [HIST_W:0]   shifted;
  logic [WIN_W-1:0]  window;
  logic              lvl_q;
  logic              pol_q;

  function automatic logic all_same(input logic [WIN_W-1:0] w);
    return (&w) | ~(|w);
  endfunction

  assign window    = {hist_q, smp_i};
  assign agree_o   = all_same(window);
  assign pol_chg_o = (rise_sel_i != pol_q);
  assign accept_o  = !pol_chg_o && (smp_i != lvl_q) && (!filt_en_i || agree_o);
  assign hit_o     = accept_o && en_i && edge_selected(smp_i, rise_sel_i);

  always_comb begin
    shifted = {hist_q, smp_i};
    if (pol_chg_o) hist_d = {HIST_W{lvl_q}};
    else           hist_d = shifted[HIST_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      lvl_q  <= 1'b0;
      pol_q  <= SEL_FALL;
    end else begin
      hist_q <= hist_d;
      pol_q  <= rise_sel_i;
      if (accept_o) lvl_q <= smp_i;
    end
  end
endmodule

// File: rtl/ecap_store.sv
module ecap_store #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] val_o,
  output logic             evt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_o <= '0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= load_i;
      if (load_i) val_o <= cnt_i;
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned FILT_LEN    = FILT_LEN_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             en_i,
  input  logic             rise_sel_i,
  input  logic             filt_en_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_evt_o
);
  // named internal events, observed by the bound checker
  logic smp;
  logic agree;
  logic pol_chg;
  logic accept;
  logic hit;

  ecap_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(smp)
  );

  ecap_qual #(.FILT_LEN(FILT_LEN)) qual_i (
    .clk(clk), .rst_n(rst_n), .smp_i(smp), .rise_sel_i(rise_sel_i),
    .filt_en_i(filt_en_i), .en_i(en_i), .agree_o(agree),
    .pol_chg_o(pol_chg), .accept_o(accept), .hit_o(hit)
  );

  ecap_store #(.CNT_W(CNT_W)) store_i (
    .clk(clk), .rst_n(rst_n), .load_i(hit), .cnt_i(cnt_i),
    .val_o(cap_val_o), .evt_o(cap_evt_o)
  );
endmodule

// File: rtl/ecap_chk.sv
module ecap_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             en_i,
  input logic             rise_sel_i,
  input logic             filt_en_i,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_evt_o,
  input logic             smp,
  input logic             agree,
  input logic             accept,
  input logic             pol_chg
);
  // R5
  evt_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_o |=> !cap_evt_o);

  // R6
  val_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt_o |-> $stable(cap_val_o));

  // R2
  val_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_o |-> cap_val_o == $past(cnt_i));

  // R7
  armed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_o |-> $past(en_i));

  // R4
  polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_o |-> ($past(smp) == $past(rise_sel_i)) && $past(accept));

  // R3
  filter_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt_o && $past(filt_en_i)) |-> $past(agree));

  // R8
  pol_switch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol_chg |=> !cap_evt_o);
endmodule

bind edge_capture_unit ecap_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .en_i(en_i),
  .rise_sel_i(rise_sel_i), .filt_en_i(filt_en_i), .cap_val_o(cap_val_o),
  .cap_evt_o(cap_evt_o), .smp(smp), .agree(agree), .accept(accept),
  .pol_chg(pol_chg)
);

// File: tb/edge_capture_unit_tb_top.sv
module edge_capture_unit_tb_top;
  localparam int FL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_i = 1'b0;
  logic [15:0] cnt_i = 16'h0;
  logic        en_i = 1'b0;
  logic        rise_sel_i = 1'b0;
  logic        filt_en_i = 1'b0;
  logic [15:0] cap_val_o;
  logic        cap_evt_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  edge_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cnt_i(cnt_i), .en_i(en_i),
    .rise_sel_i(rise_sel_i), .filt_en_i(filt_en_i),
    .cap_val_o(cap_val_o), .cap_evt_o(cap_evt_o)
  );

  // requirement-level model: two-sample delay, run length of equal samples
  logic        m_d1, m_d2, m_last, m_lvl, m_pol, m_evt;
  logic [15:0] m_val;
  int          m_run;

  function automatic int need_run(input logic filt);
    return filt ? FL : 1;
  endfunction

  always @(posedge clk) begin
    logic x;
    if (!rst_n) begin
      m_d1 = 0; m_d2 = 0; m_last = 0; m_lvl = 0; m_pol = 0;
      m_evt = 0; m_val = 0; m_run = 0;
    end else begin
      x = m_d2; m_d2 = m_d1; m_d1 = pin_i;
      m_evt = 0;
      if (rise_sel_i != m_pol) begin
        m_pol = rise_sel_i; m_run = 0; m_last = m_lvl;
      end else begin
        if (x == m_last) m_run = (m_run < FL) ? m_run + 1 : m_run;
        else m_run = 1;
        m_last = x;
        if (m_run >= need_run(filt_en_i) && x != m_lvl) begin
          m_lvl = x;
          if (en_i && (x == rise_sel_i)) m_evt = 1;
        end
      end
      if (m_evt) m_val = cnt_i;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: sample at the falling edge against the model, then advance counter
  task automatic tick(input int step = 1);
    @(negedge clk);
    check(filt_en_i ? "R3 model evt" : "R2 model evt", {31'd0, cap_evt_o}, {31'd0, m_evt});
    check(filt_en_i ? "R3 model val" : "R2 model val", {16'd0, cap_val_o}, {16'd0, m_val});
    cnt_i = cnt_i + step[15:0];
  endtask

  task automatic ticks_quiet(input int n, input string req, input logic [15:0] hold);
    for (int i = 0; i < n; i++) begin
      tick();
      check(req, {31'd0, cap_evt_o}, 32'd0);
      check(req, {16'd0, cap_val_o}, {16'd0, hold});
    end
  endtask

  initial begin
    logic [15:0] base, held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 evt in reset", {31'd0, cap_evt_o}, 32'd0);
    check("R1 val in reset", {16'd0, cap_val_o}, 32'd0);
    rst_n = 1'b1;
    rise_sel_i = 1'b1; en_i = 1'b1;
    tick(); tick(); tick();
    check("R1 evt after reset", {31'd0, cap_evt_o}, 32'd0);
    check("R1 val after reset", {16'd0, cap_val_o}, 32'd0);

    // R2 unfiltered rising edge latency and captured count
    pin_i = 1'b1; base = cnt_i;
    tick(); tick();
    check("R2 no evt early", {31'd0, cap_evt_o}, 32'd0);
    tick();
    check("R2 evt", {31'd0, cap_evt_o}, 32'd1);
    check("R2 val", {16'd0, cap_val_o}, {16'd0, base + 16'd2});
    held = cap_val_o;
    // R5 single pulse, R6 hold while level stays
    ticks_quiet(6, "R5 R6 steady level", held);

    // R4 opposite (falling) edge ignored while rising selected
    pin_i = 1'b0;
    ticks_quiet(8, "R4 falling ignored", held);

    // R4 falling selected
    rise_sel_i = 1'b0;
    ticks_quiet(3, "R8 pol flip steady", held);
    pin_i = 1'b1;
    ticks_quiet(6, "R4 rising ignored", held);
    pin_i = 1'b0; base = cnt_i;
    tick(); tick(); tick();
    check("R4 falling evt", {31'd0, cap_evt_o}, 32'd1);
    check("R4 falling val", {16'd0, cap_val_o}, {16'd0, base + 16'd2});
    held = cap_val_o;
    tick();

    // R3 filter: short pulse rejected, four-sample level accepted
    rise_sel_i = 1'b1; filt_en_i = 1'b1;
    ticks_quiet(4, "R8 pol flip steady", held);
    pin_i = 1'b1; tick(); tick(); tick();
    pin_i = 1'b0;
    ticks_quiet(10, "R3 short pulse", held);
    pin_i = 1'b1; base = cnt_i;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R3 no evt early", {31'd0, cap_evt_o}, 32'd0);
    end
    tick();
    check("R3 filtered evt", {31'd0, cap_evt_o}, 32'd1);
    check("R3 filtered val", {16'd0, cap_val_o}, {16'd0, base + 16'd5});
    held = cap_val_o;
    tick();

    // R7 disarmed edges neither captured nor replayed on re-arm
    filt_en_i = 1'b0; en_i = 1'b0;
    pin_i = 1'b0; ticks_quiet(5, "R7 disarmed", held);
    pin_i = 1'b1; ticks_quiet(6, "R7 disarmed", held);
    en_i = 1'b1; ticks_quiet(6, "R7 rearm no replay", held);

    // R8 polarity flip while edge pending: requalifies one cycle later
    pin_i = 1'b0; base = cnt_i;
    tick(); tick();
    rise_sel_i = 1'b0;
    tick();
    check("R8 suppressed at flip", {31'd0, cap_evt_o}, 32'd0);
    tick();
    check("R8 requalified evt", {31'd0, cap_evt_o}, 32'd1);
    check("R8 requalified val", {16'd0, cap_val_o}, {16'd0, base + 16'd3});
    held = cap_val_o;
    tick();
    for (int i = 0; i < 6; i++) begin
      rise_sel_i = ~rise_sel_i;
      tick();
      check("R8 toggle steady", {31'd0, cap_evt_o}, 32'd0);
    end
    check("R8 toggle steady val", {16'd0, cap_val_o}, {16'd0, held});

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) pin_i = ~pin_i;
      if ($urandom_range(0, 59) == 0) rise_sel_i = ~rise_sel_i;
      if ($urandom_range(0, 79) == 0) filt_en_i = ~filt_en_i;
      if ($urandom_range(0, 49) == 0) en_i = ~en_i;
      tick(int'($urandom_range(1, 300)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule